// File: doc/BRIEF.md
# Latency-Aware Operand Wakeup Entry

This block holds the wakeup state for one scheduler slot whose instruction has two source operands. Each source keeps the tag of the value it waits for. It watches a set of destination-tag buses, and each bus carries its own valid bit. When a valid bus carries the tag of a source, that source does not become ready at once. It loads a countdown value, chosen by the producer's latency, into a shift register. From then on a sticky match flag shifts that register right by one each clock, copying the top bit down. The least significant bit of the register is the source's ready flag. The slot raises its request when both sources are ready.

The countdown is a thermometer code: ones in the upper bits and K zeros at the bottom. A source therefore turns ready K clock edges after its tag is seen. For single-cycle scheduling, a producer of latency N is given N-1 low zeros. For a scheduler pipelined over two stages, a producer of latency 1 or 2 is all ones and a producer of latency N is given N-2 low zeros. The allocation logic picks the encoding, and so does the preloaded match and shift state that covers a tag broadcast before the slot was written.

When the select logic grants the slot, the slot's destination tag goes out on its broadcast port in that same cycle, and both sources lose their match and shift state so that the slot does not ask again. If a tag appears again later, for example when a load that missed is replayed, the source wakes again.

Top module: `rse_wakeup`

## Requirements
- R1: After reset, every src_ready bit and request are 0.
- R2: A source's tag is hit when any bus i has bus_valid[i]=1 and bus_tag[i] equals the source's tag. A tag that appears only on a bus whose valid bit is 0 changes nothing.
- R3: On a hit edge (no allocation, no grant), the source sets its match flag and loads its stored countdown into the shift register. While match is set, the register shifts right arithmetically on every following edge. src_ready is bit 0 of the register.
- R4: A countdown with K low zeros and ones above makes src_ready rise exactly K edges after the hit edge. With single-cycle encoding (K=N-1), producer latencies 1 to 4 give 0, 1, 2 and 3 edges.
- R5: With pipelined encoding, a latency-3 producer uses 1110 and turns ready one edge after the hit edge, while latencies 1 and 2 use 1111 and turn ready on the hit edge.
- R6: request is 1 exactly when every src_ready bit is 1.
- R7: A grant edge without allocation clears match and shift in both sources, so src_ready and request are 0 after it. This holds even when a hit occurs in the same cycle.
- R8: While grant is 1, bcast_valid is 1 and bcast_tag equals the destination tag written at the last allocation, in that same cycle.
- R9: On an allocation edge, each source takes its tag and countdown, and takes the preloaded match and shift values. If that source's new tag is hit in the same cycle, the source instead sets match and loads the new countdown.
- R10: A hit on a source that is already matched, or already ready, reloads the countdown. The ready time restarts, which supports replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Write a new instruction into the slot |
| alloc_dst_tag | input | TAG_W | Destination tag of the new instruction |
| alloc_src_tag | input | NUM_SRC x TAG_W | Source tags |
| alloc_delay | input | NUM_SRC x SHIFT_W | Countdown values per source |
| alloc_match | input | NUM_SRC | Preloaded match flags |
| alloc_shift | input | NUM_SRC x SHIFT_W | Preloaded shift registers |
| bus_valid | input | NUM_BUS | Valid bit per tag bus |
| bus_tag | input | NUM_BUS x TAG_W | Tag per bus |
| grant | input | 1 | Slot selected this cycle |
| src_ready | output | NUM_SRC | Ready flag per source |
| request | output | 1 | All sources ready |
| bcast_valid | output | 1 | Destination tag broadcast valid |
| bcast_tag | output | TAG_W | Broadcast destination tag |

## Verification
The assertions assume that every countdown and every preloaded shift value is a thermometer code, meaning a block of ones above a block of zeros. They also assume that a preloaded shift is zero whenever its preloaded match flag is clear. The random stimulus builds countdowns only as all ones shifted left by 0 to SHIFT_W-1 places, and it preloads either an unmatched all-zero register or a matched legal code. Tags are drawn from a small pool so that hits, collisions with allocation and replays happen often.

// File: rtl/rse_wake_pkg.sv
// Shared defaults and the next-state action type for the wakeup entry.
// Assumes: nothing beyond IEEE 1800-2017.
package rse_wake_pkg;
    localparam int DEF_TAG_W   = 6;
    localparam int DEF_NUM_BUS = 2;
    localparam int DEF_SHIFT_W = 4;
    localparam int DEF_NUM_SRC = 2;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_SHIFT,
        ACT_LOAD,
        ACT_CLEAR,
        ACT_ALLOC_HIT,
        ACT_ALLOC_PRE
    } wake_act_e;
endpackage

// File: rtl/rse_tag_hit.sv
// Compares one tag against every destination-tag bus and reports a hit.
// Assumes: bus entries whose valid bit is clear carry meaningless tags.
module rse_tag_hit #(
    parameter int TAG_W   = 6,
    parameter int NUM_BUS = 2
) (
    input  logic [TAG_W-1:0]              tag_i,
    input  logic [NUM_BUS-1:0]            bus_valid_i,
    input  logic [NUM_BUS-1:0][TAG_W-1:0] bus_tag_i,
    output logic                          hit_o
);
    logic [NUM_BUS-1:0] lane_hit;

    // One comparator per bus, gated by that bus's valid bit.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_lane
        assign lane_hit[b] = bus_valid_i[b] && (bus_tag_i[b] == tag_i);
    end

    assign hit_o = |lane_hit;
endmodule

// File: rtl/rse_src_wakeup.sv
// Wakeup state of one source: tag, countdown, sticky match and shift register.
// Ready is bit 0 of the shift register. Priority: allocation, grant, hit, shift.
// Assumes: countdown and preload values are thermometer codes (ones over zeros).
module rse_src_wakeup
    import rse_wake_pkg::*;
#(
    parameter int TAG_W   = 6,
    parameter int NUM_BUS = 2,
    parameter int SHIFT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    input  logic [TAG_W-1:0]              alloc_tag_i,
    input  logic [SHIFT_W-1:0]            alloc_delay_i,
    input  logic                          alloc_match_i,
    input  logic [SHIFT_W-1:0]            alloc_shift_i,
    input  logic                          grant_i,
    input  logic [NUM_BUS-1:0]            bus_valid_i,
    input  logic [NUM_BUS-1:0][TAG_W-1:0] bus_tag_i,
    output logic                          ready_o
);
    logic [TAG_W-1:0]   tag_q;
    logic [TAG_W-1:0]   cmp_tag;
    logic [SHIFT_W-1:0] delay_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               match_q;
    logic               hit;
    wake_act_e          act;

    // Compare the incoming tag while allocating, the stored tag otherwise.
    assign cmp_tag = alloc_i ? alloc_tag_i : tag_q;

    rse_tag_hit #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) hit_i (
        .tag_i       (cmp_tag),
        .bus_valid_i (bus_valid_i),
        .bus_tag_i   (bus_tag_i),
        .hit_o       (hit)
    );

    // Pick the single state action for this cycle by priority.
    always_comb begin
        if (alloc_i)      act = hit ? ACT_ALLOC_HIT : ACT_ALLOC_PRE;
        else if (grant_i) act = ACT_CLEAR;
        else if (hit)     act = ACT_LOAD;
        else if (match_q) act = ACT_SHIFT;
        else              act = ACT_HOLD;
    end

    // Apply the chosen action to tag, countdown, match and shift state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            delay_q <= '0;
            shift_q <= '0;
            match_q <= 1'b0;
        end else begin
            case (act)
                ACT_ALLOC_HIT: begin
                    tag_q   <= alloc_tag_i;
                    delay_q <= alloc_delay_i;
                    match_q <= 1'b1;
                    shift_q <= alloc_delay_i;
                end
                ACT_ALLOC_PRE: begin
                    tag_q   <= alloc_tag_i;
                    delay_q <= alloc_delay_i;
                    match_q <= alloc_match_i;
                    shift_q <= alloc_shift_i;
                end
                ACT_CLEAR: begin
                    match_q <= 1'b0;
                    shift_q <= '0;
                end
                ACT_LOAD: begin
                    match_q <= 1'b1;
                    shift_q <= delay_q;
                end
                ACT_SHIFT: shift_q <= {shift_q[SHIFT_W-1], shift_q[SHIFT_W-1:1]};
                default:   shift_q <= shift_q;
            endcase
        end
    end

    assign ready_o = shift_q[0];

    // R3: an idle matched source shifts arithmetically right once per edge.
    a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (match_q && !alloc_i && !grant_i && !hit) |=>
        (shift_q == {$past(shift_q[SHIFT_W-1]), $past(shift_q[SHIFT_W-1:1])}));

    // R3: a hit loads the stored countdown and sets the sticky match.
    a_r3_hit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !alloc_i && !grant_i) |=> (match_q && shift_q == $past(delay_q)));

    // R7: a grant without allocation leaves no match and no countdown.
    a_r7_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !alloc_i) |=> (!match_q && shift_q == '0));

    // R9: a hit during allocation beats the preloaded values.
    a_r9_alloc_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && hit) |=> (match_q && shift_q == $past(alloc_delay_i)));
endmodule

// File: rtl/rse_wakeup.sv
// Two-source scheduler slot: per-source latency-aware wakeup, combined
// request, and destination-tag broadcast on grant.
// Assumes: grant only arrives while request is high or is otherwise harmless.
module rse_wakeup
    import rse_wake_pkg::*;
#(
    parameter int TAG_W   = DEF_TAG_W,
    parameter int NUM_BUS = DEF_NUM_BUS,
    parameter int SHIFT_W = DEF_SHIFT_W,
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    input  logic [TAG_W-1:0]              alloc_dst_tag,
    input  logic [NUM_SRC-1:0][TAG_W-1:0] alloc_src_tag,
    input  logic [NUM_SRC-1:0][SHIFT_W-1:0] alloc_delay,
    input  logic [NUM_SRC-1:0]            alloc_match,
    input  logic [NUM_SRC-1:0][SHIFT_W-1:0] alloc_shift,
    input  logic [NUM_BUS-1:0]            bus_valid,
    input  logic [NUM_BUS-1:0][TAG_W-1:0] bus_tag,
    input  logic                          grant,
    output logic [NUM_SRC-1:0]            src_ready,
    output logic                          request,
    output logic                          bcast_valid,
    output logic [TAG_W-1:0]              bcast_tag
);
    logic [TAG_W-1:0] dst_q;

    // One wakeup tracker per source operand.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rse_src_wakeup #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS), .SHIFT_W(SHIFT_W)) src_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (alloc_valid),
            .alloc_tag_i   (alloc_src_tag[s]),
            .alloc_delay_i (alloc_delay[s]),
            .alloc_match_i (alloc_match[s]),
            .alloc_shift_i (alloc_shift[s]),
            .grant_i       (grant),
            .bus_valid_i   (bus_valid),
            .bus_tag_i     (bus_tag),
            .ready_o       (src_ready[s])
        );
    end

    // Hold the destination tag of the instruction in the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)           dst_q <= '0;
        else if (alloc_valid) dst_q <= alloc_dst_tag;
    end

    assign request     = &src_ready;
    assign bcast_valid = grant;
    assign bcast_tag   = dst_q;

    // R7: the slot never asks again on the edge after a plain grant.
    a_r7_no_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !alloc_valid) |=> !request);

    // R8: the broadcast tag is the one written at the most recent allocation.
    a_r8_bcast_tag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alloc_valid) && bcast_valid) |-> (bcast_tag == $past(alloc_dst_tag)));
endmodule

// File: tb/rse_wakeup_tb.sv
// Self-checking bench: directed latency and corner cases, then seeded random
// traffic checked against a trailing-zero-count model of each source.
module rse_wakeup_tb_top;
    localparam int TAG_W = 6, NUM_BUS = 2, SHIFT_W = 4, NUM_SRC = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic alloc_valid;
    logic [TAG_W-1:0] alloc_dst_tag;
    logic [NUM_SRC-1:0][TAG_W-1:0] alloc_src_tag;
    logic [NUM_SRC-1:0][SHIFT_W-1:0] alloc_delay;
    logic [NUM_SRC-1:0] alloc_match;
    logic [NUM_SRC-1:0][SHIFT_W-1:0] alloc_shift;
    logic [NUM_BUS-1:0] bus_valid;
    logic [NUM_BUS-1:0][TAG_W-1:0] bus_tag;
    logic grant;
    logic [NUM_SRC-1:0] src_ready;
    logic request, bcast_valid;
    logic [TAG_W-1:0] bcast_tag;

    int n_cmp = 0, n_bad = 0;

    // Model state: tag, countdown zeros, match, live zeros, register nonzero.
    logic [TAG_W-1:0] m_tag [NUM_SRC];
    int   m_dk [NUM_SRC];
    bit   m_match [NUM_SRC];
    int   m_z [NUM_SRC];
    bit   m_nz [NUM_SRC];
    logic [TAG_W-1:0] m_dst;

    always #4 clk = ~clk;

    rse_wakeup #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS), .SHIFT_W(SHIFT_W), .NUM_SRC(NUM_SRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dst_tag(alloc_dst_tag),
        .alloc_src_tag(alloc_src_tag), .alloc_delay(alloc_delay), .alloc_match(alloc_match),
        .alloc_shift(alloc_shift), .bus_valid(bus_valid), .bus_tag(bus_tag), .grant(grant),
        .src_ready(src_ready), .request(request), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
    );

    function automatic logic [SHIFT_W-1:0] enc(int k);
        return {SHIFT_W{1'b1}} << k;
    endfunction

    function automatic bit bus_hit(logic [TAG_W-1:0] t);
        for (int b = 0; b < NUM_BUS; b++)
            if (bus_valid[b] && bus_tag[b] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; alloc_dst_tag = '0; alloc_src_tag = '0; alloc_delay = '0;
        alloc_match = '0; alloc_shift = '0; bus_valid = '0; bus_tag = '0; grant = 0;
    endtask

    // Set up an allocation: delay zeros dk[s], preload match/zeros (pz<0: empty).
    task automatic set_alloc(logic [TAG_W-1:0] dst, logic [TAG_W-1:0] t0, logic [TAG_W-1:0] t1,
                             int d0, int d1, int p0, int p1);
        alloc_valid = 1; alloc_dst_tag = dst;
        alloc_src_tag[0] = t0; alloc_src_tag[1] = t1;
        alloc_delay[0] = enc(d0); alloc_delay[1] = enc(d1);
        alloc_match[0] = (p0 >= 0); alloc_shift[0] = (p0 >= 0) ? enc(p0) : '0;
        alloc_match[1] = (p1 >= 0); alloc_shift[1] = (p1 >= 0) ? enc(p1) : '0;
    endtask

    function automatic int zeros_of(logic [SHIFT_W-1:0] v);
        for (int i = 0; i < SHIFT_W; i++) if (v[i]) return i;
        return SHIFT_W;
    endfunction

    // One clock: check broadcast, advance the model, then compare outputs.
    task automatic cycle();
        bit exp_req;
        bit nmatch [NUM_SRC];
        int nz_cnt [NUM_SRC];
        bit nnz [NUM_SRC];
        #1;
        check("R8 bcast_valid", bcast_valid, grant);
        if (grant) check("R8 bcast_tag", bcast_tag, m_dst);
        for (int s = 0; s < NUM_SRC; s++) begin
            nmatch[s] = m_match[s]; nz_cnt[s] = m_z[s]; nnz[s] = m_nz[s];
            if (alloc_valid) begin
                if (bus_hit(alloc_src_tag[s])) begin
                    nmatch[s] = 1; nz_cnt[s] = zeros_of(alloc_delay[s]); nnz[s] = 1;
                end else begin
                    nmatch[s] = alloc_match[s]; nnz[s] = (alloc_shift[s] != '0);
                    nz_cnt[s] = zeros_of(alloc_shift[s]);
                end
            end else if (grant) begin
                nmatch[s] = 0; nnz[s] = 0; nz_cnt[s] = SHIFT_W;
            end else if (bus_hit(m_tag[s])) begin
                nmatch[s] = 1; nz_cnt[s] = m_dk[s]; nnz[s] = 1;
            end else if (m_match[s] && m_nz[s] && m_z[s] > 0) begin
                nz_cnt[s] = m_z[s] - 1;
            end
        end
        if (alloc_valid) begin
            m_dst = alloc_dst_tag;
            for (int s = 0; s < NUM_SRC; s++) begin
                m_tag[s] = alloc_src_tag[s]; m_dk[s] = zeros_of(alloc_delay[s]);
            end
        end
        @(posedge clk);
        #1;
        exp_req = 1;
        for (int s = 0; s < NUM_SRC; s++) begin
            m_match[s] = nmatch[s]; m_z[s] = nz_cnt[s]; m_nz[s] = nnz[s];
            check("R3/R4 src_ready", src_ready[s], (m_nz[s] && m_z[s] == 0));
            if (!(m_nz[s] && m_z[s] == 0)) exp_req = 0;
        end
        check("R6 request", request, exp_req);
        idle_inputs();
    endtask

    task automatic hit_on(logic [TAG_W-1:0] t, int lane);
        bus_valid[lane] = 1; bus_tag[lane] = t;
    endtask

    // Count edges from a hit edge until request rises; returns the count.
    task automatic edges_to_request(output int n);
        n = 0;
        while (!request && n < 10) begin
            cycle(); n++;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        process::self().srandom(32'd1234);
        idle_inputs();
        for (int s = 0; s < NUM_SRC; s++) begin
            m_tag[s] = '0; m_dk[s] = 0; m_match[s] = 0; m_z[s] = SHIFT_W; m_nz[s] = 0;
        end
        m_dst = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        // R1: reset state.
        check("R1 src_ready", src_ready, 0);
        check("R1 request", request, 0);

        // R4: single-cycle encoding, latencies 1..4 -> N-1 edges.
        for (int lat = 1; lat <= 4; lat++) begin
            set_alloc(6'd40 + lat, 6'd5, 6'd6, lat - 1, 0, -1, 0);
            cycle();
            hit_on(6'd5, lat % 2);
            cycle();
            n = request ? 0 : 1;
            if (!request) begin
                int more;
                edges_to_request(more);
                n = more;
            end
            check("R4 edges after hit", n, lat - 1);
            grant = 1; cycle();
        end

        // R5: pipelined encoding, latency 3 uses 1110 -> one edge.
        set_alloc(6'd50, 6'd7, 6'd8, 1, 0, -1, 0);
        cycle();
        hit_on(6'd7, 0); cycle();
        check("R5 not ready on hit edge", src_ready[0], 0);
        cycle();
        check("R5 ready one edge later", src_ready[0], 1);
        grant = 1; cycle();

        // R2: invalid bus lane carrying the tag is ignored.
        set_alloc(6'd51, 6'd9, 6'd10, 0, 0, -1, -1);
        cycle();
        bus_valid = 2'b00; bus_tag[0] = 6'd9; bus_tag[1] = 6'd10; cycle();
        check("R2 invalid lane ignored", src_ready, 0);
        hit_on(6'd9, 1); hit_on(6'd10, 0); cycle();
        check("R2 valid lanes hit", src_ready, 2'b11);

        // R7: grant beats a same-cycle hit.
        grant = 1; hit_on(6'd9, 0); cycle();
        check("R7 cleared despite hit", src_ready, 0);

        // R9: allocation with same-cycle hit beats preload.
        set_alloc(6'd52, 6'd11, 6'd12, 2, 0, 0, 0);
        hit_on(6'd11, 0); cycle();
        check("R9 hit overrides preload", src_ready[0], 0);
        cycle(); cycle();
        check("R9 ready after countdown", src_ready[0], 1);

        // R10: replay reloads the countdown on a ready source.
        hit_on(6'd11, 1); cycle();
        check("R10 replay drops ready", src_ready[0], 0);
        cycle(); cycle();
        check("R10 replay ready again", src_ready[0], 1);
        grant = 1; cycle();

        // Random traffic mixed with the model.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(7) == 0)
                set_alloc(6'($urandom_range(63)), 6'($urandom_range(7)), 6'($urandom_range(7)),
                          $urandom_range(SHIFT_W - 1), $urandom_range(SHIFT_W - 1),
                          $urandom_range(1) ? -1 : int'($urandom_range(SHIFT_W - 1)),
                          $urandom_range(1) ? -1 : int'($urandom_range(SHIFT_W - 1)));
            grant = ($urandom_range(5) == 0);
            for (int b = 0; b < NUM_BUS; b++) begin
                bus_valid[b] = ($urandom_range(2) == 0);
                bus_tag[b] = 6'($urandom_range(7));
            end
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule